// File: doc/BRIEF.md
# Dual-register serial front end for eight discrete inputs

This block is the digital side of an eight-channel discrete input sensor. One SPI-style slave port serves two 8-bit shift registers. A select input chooses the register at the start of each frame. The snapshot register captures the eight already-digitised discrete levels when chip select falls, and the master then shifts them out. The format register takes eight per-channel format bits from the master. When chip select rises, those bits are committed to a parallel output that drives the analog threshold circuits.

Everything runs on one system clock. Chip select, the serial clock and the serial input each pass through a two-stage synchroniser, and edges are detected on the synchronised copies. The serial clock must therefore stay low and high for several system clock periods. The serial output is a data bit plus an output enable, which the pad ring turns into a tri-state driver.

Top module: `discrete_spi_front`

## Requirements
- R1: After reset, `cfg_o` is all zeros, so every channel is in ground/open format, and `sdo_oe_o` is low.
- R2: While `cs_n_i` is high, `sdo_oe_o` is low, and serial clock edges change neither shift register.
- R3: While `cs_n_i` is low, each rising `sclk_i` edge shifts `sdi_i` into bit 0 of the active register and moves every bit one place toward bit 7.
- R4: While `cs_n_i` is low, `sdo_oe_o` is high and `sdo_o` shows bit 7 of the active register. The master therefore reads bit 7 first, before the first rising edge.
- R5: A falling edge of `cs_n_i` while `reg_sel_i` is high (1 = snapshot, 0 = format) loads `disc_i` into the snapshot register. Channel n sits in bit n-1, so channel 8 (`disc_i[7]`) is read first. Changes on `disc_i` later in the frame have no effect.
- R6: A rising edge of `cs_n_i` that ends a format frame copies the format shift register into `cfg_o`. Bit n-1 sets channel n: 0 selects ground/open and 1 selects 28 V/open.
- R7: `cfg_o` stays unchanged while bits shift, and at the end of a snapshot frame.
- R8: `reg_sel_i` is sampled at the falling edge of `cs_n_i` and held for the whole frame. A change in mid-frame neither switches the register nor changes whether the frame commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in |
| reg_sel_i | input | 1 | 1 = snapshot register, 0 = format register |
| disc_i | input | 8 | Digitised discrete levels, channel n in bit n-1 |
| sdo_o | output | 1 | Serial data out, bit 7 of the active register |
| sdo_oe_o | output | 1 | Output enable for the serial out pad |
| cfg_o | output | 8 | Latched per-channel format bits |

## Verification
Frames of 16 clocks check that bit 0 really takes the serial input. Past the eighth bit, the first bits that were shifted in must appear, so a design that drops or duplicates a bit shows a shifted pattern. Clocks sent while chip select is high, followed by a format frame that reads back the old contents, catch a register that shifts while deselected. Flipping the select input and the discrete levels in mid-frame catches a design that reloads the snapshot, switches registers during a frame, or commits at the end of a snapshot frame. Sampling `cfg_o` in mid-frame catches outputs that follow the shift register instead of the latch.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
  typedef enum logic {
    SEL_FMT  = 1'b0,
    SEL_SNAP = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dsi_sync.sv
module dsi_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dsi_edge.sv
module dsi_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= d_i;
  end

  assign rise_o = d_i & ~prev_q;
  assign fall_o = ~d_i & prev_q;
endmodule

// File: rtl/dsi_shreg.sv
module dsi_shreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         sin_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (load_i)  q_o <= load_val_i;
    else if (shift_i) q_o <= {q_o[W-2:0], sin_i};
  end

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(q_o));

  p_shift_lsb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> (q_o[0] == $past(sin_i)) && (q_o[W-1:1] == $past(q_o[W-2:0])));
endmodule

// File: rtl/discrete_spi_front.sv
module discrete_spi_front
  import dsi_pkg::*;
#(
  parameter int N_CH        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_n_i,
  input  logic            sclk_i,
  input  logic            sdi_i,
  input  logic            reg_sel_i,
  input  logic [N_CH-1:0] disc_i,
  output logic            sdo_o,
  output logic            sdo_oe_o,
  output logic [N_CH-1:0] cfg_o
);
  localparam int MSB = N_CH - 1;

  logic cs_s, sclk_s, sdi_s;
  logic cs_rise, cs_fall, sclk_rise, sclk_fall_unused;
  reg_sel_e sel_q;
  logic [N_CH-1:0] snap_sr, fmt_sr;
  logic snap_load, snap_shift, fmt_shift, commit;

  dsi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({cs_n_i, sclk_i, sdi_i}),
    .q_o ({cs_s, sclk_s, sdi_s})
  );

  dsi_edge #(.RST_VAL(1'b1)) u_cs_edge (
    .clk_i, .rst_ni, .d_i(cs_s), .rise_o(cs_rise), .fall_o(cs_fall)
  );

  dsi_edge #(.RST_VAL(1'b0)) u_sclk_edge (
    .clk_i, .rst_ni, .d_i(sclk_s), .rise_o(sclk_rise), .fall_o(sclk_fall_unused)
  );

  // frame register choice, frozen for the frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= SEL_FMT;
    else if (cs_fall) sel_q <= reg_sel_e'(reg_sel_i);
  end

  assign snap_load  = cs_fall && reg_sel_i;
  assign snap_shift = sclk_rise && !cs_s && !cs_fall && (sel_q == SEL_SNAP);
  assign fmt_shift  = sclk_rise && !cs_s && !cs_fall && (sel_q == SEL_FMT);
  assign commit     = cs_rise && (sel_q == SEL_FMT);

  dsi_shreg #(.W(N_CH)) u_snap_sr (
    .clk_i, .rst_ni,
    .load_i(snap_load), .load_val_i(disc_i),
    .shift_i(snap_shift), .sin_i(sdi_s), .q_o(snap_sr)
  );

  dsi_shreg #(.W(N_CH)) u_fmt_sr (
    .clk_i, .rst_ni,
    .load_i(1'b0), .load_val_i('0),
    .shift_i(fmt_shift), .sin_i(sdi_s), .q_o(fmt_sr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_o <= '0;
    else if (commit) cfg_o <= fmt_sr;
  end

  assign sdo_o    = (sel_q == SEL_SNAP) ? snap_sr[MSB] : fmt_sr[MSB];
  assign sdo_oe_o = !cs_s;

  p_snap_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_fall && reg_sel_i) |=> (snap_sr == $past(disc_i)));

  p_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise && sel_q == SEL_FMT) |=> (cfg_o == $past(fmt_sr)));

  p_cfg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_rise && sel_q == SEL_FMT) |=> $stable(cfg_o));

  p_sel_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_fall |=> $stable(sel_q));

  p_no_shift_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_s && !cs_fall) |=> ($stable(fmt_sr) && $stable(snap_sr)));
endmodule

// File: tb/test_discrete_spi_front.sv
module test_discrete_spi_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, reg_sel = 1'b1;
  logic [7:0] disc = '0;
  logic sdo, sdo_oe;
  logic [7:0] cfg;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic  exp_q[$];
  string tag_q[$];
  event  sample_ev;

  always #5 clk = ~clk;

  discrete_spi_front i_discrete_spi_front (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .reg_sel_i(reg_sel), .disc_i(disc), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .cfg_o(cfg)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops the expected serial bit and compares with the pin
  initial begin
    forever begin
      @(sample_ev);
      chk({tag_q[0], " sdo_oe (R4)"}, {15'd0, sdo_oe}, 16'd1);
      chk(tag_q.pop_front(), {15'd0, sdo}, {15'd0, exp_q.pop_front()});
    end
  end

  // driver: one frame; expected readout pushed per bit, MSB of word first
  task automatic frame(input logic sel, input logic sel_mid, input int nb,
                       input logic [15:0] din, input logic [15:0] exp,
                       input logic [7:0] disc_start, input logic [7:0] disc_mid,
                       input logic [7:0] cfg_hold, input string tag);
    disc    = disc_start;
    reg_sel = sel;
    wait_cyc(2);
    cs_n = 1'b0;
    wait_cyc(8);
    disc    = disc_mid;
    reg_sel = sel_mid;
    for (int i = 0; i < nb; i++) begin
      sdi = din[nb-1-i];
      exp_q.push_back(exp[nb-1-i]);
      tag_q.push_back(tag);
      -> sample_ev;
      wait_cyc(1);
      sclk = 1'b1;
      wait_cyc(8);
      sclk = 1'b0;
      wait_cyc(8);
      if (i == nb / 2) chk("R7 cfg held mid-frame", {8'd0, cfg}, {8'd0, cfg_hold});
    end
    cs_n = 1'b1;
    wait_cyc(8);
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    chk("R1 cfg after reset", {8'd0, cfg}, 16'h0000);
    chk("R1 oe after reset", {15'd0, sdo_oe}, 16'd0);

    // snapshot, 16 bits: channel 8 first, then sdi bits emerge from bit 0
    frame(1'b1, 1'b1, 16, 16'h3C00, 16'hA53C, 8'hA5, 8'h5A, 8'h00, "R5/R3 snapshot");
    chk("R7 cfg after snapshot frame", {8'd0, cfg}, 16'h0000);

    frame(1'b0, 1'b0, 8, 16'h003C, 16'h0000, 8'h00, 8'h00, 8'h00, "R3 format readout");
    chk("R6 commit 3C", {8'd0, cfg}, 16'h003C);

    // clocks while deselected must be ignored
    sdi = 1'b1;
    for (int k = 0; k < 4; k++) begin
      sclk = 1'b1; wait_cyc(8);
      chk("R2 oe low while deselected", {15'd0, sdo_oe}, 16'd0);
      sclk = 1'b0; wait_cyc(8);
    end
    frame(1'b0, 1'b0, 8, 16'h00C3, 16'h003C, 8'h00, 8'h00, 8'h3C, "R2 format untouched");
    chk("R6 commit C3", {8'd0, cfg}, 16'h00C3);

    // select dropped mid snapshot frame: stays snapshot, no commit
    frame(1'b1, 1'b0, 8, 16'h00FF, 16'h0081, 8'h81, 8'h00, 8'hC3, "R8 snapshot kept");
    chk("R8 no commit after snapshot", {8'd0, cfg}, 16'h00C3);

    // select raised mid format frame: stays format, commits last 8 bits
    frame(1'b0, 1'b1, 16, 16'h5AF0, 16'hC35A, 8'hFF, 8'hFF, 8'hC3, "R8/R3 format kept");
    chk("R6 commit F0", {8'd0, cfg}, 16'h00F0);
    chk("R2 oe low after frame", {15'd0, sdo_oe}, 16'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule